// File: doc/BRIEF.md
# Exception return integrity checker

This block carries out the return-from-exception sequence of a small microcontroller-class core. When the core writes a magic return value to its program counter, the block is started. It receives that value, the number of the exception being left, the completion status the interrupt controller reports for that exception, and a configuration bit that permits a return to thread mode while other exceptions are still active.

The check runs in two stages. First the block decodes the return value and the nesting status. If either is unacceptable, it raises a usage fault on the frame already on the stack and reads no memory. If both are acceptable, it selects the main or the process stack pointer and reads the eight-word frame, one word per read, through a single-word memory port. It then restores the stack-alignment adjustment and checks that the mode recorded in the restored status word matches the mode the return value asked for. A mismatch raises a usage fault that needs a freshly pushed frame. Exception entry itself is handled elsewhere. This block only requests it, supplying the link value and the exception number to pend.

Top module: `exc_return_checker`

## Requirements
- R1: After reset `busy_o`, `done_o`, `fault_o`, `mem_rd_o`, `invpc_o`, `faultmask_clr_o` and `hibits_warn_o` are all 0.
- R2: If any of bits 27:5 of the return value is 0, `hibits_warn_o` pulses together with the completion pulse (done or fault), and processing continues unchanged.
- R3: `faultmask_clr_o` pulses with every completion pulse, fault or not, unless the exception being left is number 2.
- R4: Nesting status is encoded as 2'b00 = others still active, 2'b01 = base level reached, 2'b11 = exception was not active. Code 2'b11, and the unused code 2'b10, cause a pre-pop fault.
- R5: The low nibble of the return value selects the return kind: 1 = handler mode on the main stack, 9 = thread mode on the main stack, 13 = thread mode on the process stack. Every other nibble causes a pre-pop fault.
- R6: A thread-mode return with status 2'b00 is a pre-pop fault unless `nonbase_thr_en_i` is 1.
- R7: A pre-pop fault issues no memory read. One cycle after the start it pulses `fault_o` with `fault_new_frame_o` = 0, `pend_exc_o` = 6 and `fault_lr_o` = return value OR 0xF0000000.
- R8: A legal return reads 8 words starting at the selected stack pointer, adding 4 after each read. Word k (R0, R1, R2, R3, R12, LR, PC, xPSR for k = 0..7) appears at `frame_o[32k+31:32k]`.
- R9: After popping, `sp_o` is the start address plus 32, ORed with 4 when bit 9 of the restored xPSR is set.
- R10: After popping, if the xPSR exception field (bits 8:0) is zero while a handler return was requested, or nonzero while a thread return was requested, `fault_o` pulses with `fault_new_frame_o` = 1, `pend_exc_o` = 6 and the same link value as in R7. Otherwise `done_o` pulses.
- R11: `invpc_o` is set by every fault and stays set until `invpc_clr_i` is pulsed while no fault is being raised.
- R12: `done_o` and `fault_o` are one-cycle pulses, never high together. `sp_o`, `frame_o`, `use_psp_o` and `handler_mode_o` are valid while either pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a return; sampled while idle |
| ret_val_i | input | 32 | Magic return value written to the PC |
| cur_exc_i | input | 9 | Number of the exception being left |
| nest_i | input | 2 | Completion status from the interrupt controller |
| nonbase_thr_en_i | input | 1 | Permit thread return while others are active |
| msp_i | input | 32 | Main stack pointer |
| psp_i | input | 32 | Process stack pointer |
| invpc_clr_i | input | 1 | Clear the sticky invalid-PC status |
| mem_rd_o | output | 1 | Word read request |
| mem_addr_o | output | 32 | Read address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Return sequence in progress |
| done_o | output | 1 | Successful return pulse |
| fault_o | output | 1 | Usage fault request pulse |
| fault_new_frame_o | output | 1 | With fault: a new frame must be pushed |
| pend_exc_o | output | 9 | Exception number to pend with the fault |
| fault_lr_o | output | 32 | Link value for fault entry |
| use_psp_o | output | 1 | Process stack selected |
| handler_mode_o | output | 1 | Handler-mode return requested |
| sp_o | output | 32 | Stack pointer after the pop |
| frame_o | output | 256 | Popped frame, word k at bits 32k+31:32k |
| faultmask_clr_o | output | 1 | Clear the fault-mask bit |
| hibits_warn_o | output | 1 | Bits 27:5 of the return value not all ones |
| invpc_o | output | 1 | Sticky invalid-PC status |

## Verification
The bench builds the block with its default widths: 32-bit data, a 9-bit exception number and an 8-word frame. A 64-word memory model places the main and process stacks at different addresses, so the stack choice shows up in every popped word. The sweep covers all 16 return nibbles against the three defined status codes, both settings of the configuration bit, an NMI and an ordinary exception, a zero and a nonzero restored exception field, both alignment-bit values and good and bad high bits. Every pre-pop and post-pop fault path and every legal return is therefore reached with exact expected values.

// File: rtl/exr_pkg.sv
package exr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POP  = 2'd1,
        ST_CHK  = 2'd2
    } exr_state_e;

    localparam logic [1:0] NEST_ACTIVE = 2'b00;
    localparam logic [1:0] NEST_BASE   = 2'b01;

    localparam logic [3:0] KIND_HANDLER    = 4'd1;
    localparam logic [3:0] KIND_THREAD_MSP = 4'd9;
    localparam logic [3:0] KIND_THREAD_PSP = 4'd13;
endpackage

// File: rtl/exr_decode.sv
module exr_decode
    import exr_pkg::*;
#(
    parameter int HI_W = 23
) (
    input  logic [3:0]      kind_i,
    input  logic [HI_W-1:0] hi_i,
    input  logic [1:0]      nest_i,
    input  logic            nonbase_thr_en_i,
    output logic            handler_o,
    output logic            use_psp_o,
    output logic            hibits_bad_o,
    output logic            pre_fault_o
);
    logic kind_ok, thread, nest_ok, nest_base;

    always_comb begin
        handler_o    = (kind_i == KIND_HANDLER);
        use_psp_o    = (kind_i == KIND_THREAD_PSP);
        thread       = (kind_i == KIND_THREAD_MSP) || use_psp_o;
        kind_ok      = handler_o || thread;
        nest_base    = (nest_i == NEST_BASE);
        nest_ok      = nest_base || (nest_i == NEST_ACTIVE);
        hibits_bad_o = ~&hi_i;
        pre_fault_o  = !kind_ok || !nest_ok ||
                       (thread && !nest_base && !nonbase_thr_en_i);
    end
endmodule

// File: rtl/exr_mode_chk.sv
module exr_mode_chk #(
    parameter int EXC_W = 9
) (
    input  logic [EXC_W-1:0] restored_exc_i,
    input  logic             handler_req_i,
    output logic             mismatch_o
);
    always_comb mismatch_o = handler_req_i == (restored_exc_i == '0);
endmodule

// File: rtl/exc_return_checker.sv
module exc_return_checker
    import exr_pkg::*;
#(
    parameter int DW          = 32,
    parameter int EXC_W       = 9,
    parameter int FRAME_WORDS = 8,
    parameter int USAGE_EXC   = 6,
    parameter int NMI_EXC     = 2,
    parameter int ALIGN_BIT   = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [DW-1:0]             ret_val_i,
    input  logic [EXC_W-1:0]          cur_exc_i,
    input  logic [1:0]                nest_i,
    input  logic                      nonbase_thr_en_i,
    input  logic [DW-1:0]             msp_i,
    input  logic [DW-1:0]             psp_i,
    input  logic                      invpc_clr_i,
    output logic                      mem_rd_o,
    output logic [DW-1:0]             mem_addr_o,
    input  logic [DW-1:0]             mem_rdata_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      fault_o,
    output logic                      fault_new_frame_o,
    output logic [EXC_W-1:0]          pend_exc_o,
    output logic [DW-1:0]             fault_lr_o,
    output logic                      use_psp_o,
    output logic                      handler_mode_o,
    output logic [DW-1:0]             sp_o,
    output logic [FRAME_WORDS*DW-1:0] frame_o,
    output logic                      faultmask_clr_o,
    output logic                      hibits_warn_o,
    output logic                      invpc_o
);
    localparam int IDX_W   = $clog2(FRAME_WORDS);
    localparam int HI_W    = DW - 9;
    localparam int XPSR_IX = FRAME_WORDS - 1;
    localparam logic [DW-1:0] WORD_BYTES = DW'(DW / 8);
    localparam logic [DW-1:0] LR_TOP     = {4'hF, {(DW-4){1'b0}}};
    localparam logic [DW-1:0] ALIGN_ADD  = DW'(4);

    typedef struct packed {
        exr_state_e                          state;
        logic [IDX_W-1:0]                    idx;
        logic                                phase;
        logic [DW-1:0]                       sp;
        logic [DW-1:0]                       lr;
        logic                                handler;
        logic                                psp;
        logic                                fm_pend;
        logic                                warn_pend;
        logic [FRAME_WORDS-1:0][DW-1:0]      frame;
        logic                                done;
        logic                                fault;
        logic                                new_frame;
        logic                                fm_clr;
        logic                                warn;
        logic                                invpc;
    } exr_st_t;

    exr_st_t st_d, st_q;

    logic dec_handler, dec_psp, dec_hibad, dec_fault, mismatch;

    exr_decode #(.HI_W(HI_W)) u_decode (
        .kind_i           (ret_val_i[3:0]),
        .hi_i             (ret_val_i[DW-5:5]),
        .nest_i           (nest_i),
        .nonbase_thr_en_i (nonbase_thr_en_i),
        .handler_o        (dec_handler),
        .use_psp_o        (dec_psp),
        .hibits_bad_o     (dec_hibad),
        .pre_fault_o      (dec_fault)
    );

    exr_mode_chk #(.EXC_W(EXC_W)) u_mode (
        .restored_exc_i (st_q.frame[XPSR_IX][EXC_W-1:0]),
        .handler_req_i  (st_q.handler),
        .mismatch_o     (mismatch)
    );

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.fault     = 1'b0;
        st_d.new_frame = 1'b0;
        st_d.fm_clr    = 1'b0;
        st_d.warn      = 1'b0;
        mem_rd_o       = 1'b0;
        if (invpc_clr_i) st_d.invpc = 1'b0;

        unique case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.lr        = ret_val_i | LR_TOP;
                    st_d.handler   = dec_handler;
                    st_d.psp       = dec_psp;
                    st_d.fm_pend   = (cur_exc_i != EXC_W'(NMI_EXC));
                    st_d.warn_pend = dec_hibad;
                    st_d.sp        = dec_psp ? psp_i : msp_i;
                    st_d.idx       = '0;
                    st_d.phase     = 1'b0;
                    if (dec_fault) begin
                        st_d.fault  = 1'b1;
                        st_d.invpc  = 1'b1;
                        st_d.fm_clr = (cur_exc_i != EXC_W'(NMI_EXC));
                        st_d.warn   = dec_hibad;
                    end else begin
                        st_d.state = ST_POP;
                    end
                end
            end
            ST_POP: begin
                if (!st_q.phase) begin
                    mem_rd_o   = 1'b1;
                    st_d.phase = 1'b1;
                end else begin
                    st_d.frame[st_q.idx] = mem_rdata_i;
                    st_d.sp              = st_q.sp + WORD_BYTES;
                    st_d.phase           = 1'b0;
                    if (st_q.idx == IDX_W'(FRAME_WORDS - 1)) st_d.state = ST_CHK;
                    else st_d.idx = st_q.idx + 1'b1;
                end
            end
            default: begin
                st_d.state  = ST_IDLE;
                st_d.sp     = st_q.frame[XPSR_IX][ALIGN_BIT] ? (st_q.sp | ALIGN_ADD) : st_q.sp;
                st_d.fm_clr = st_q.fm_pend;
                st_d.warn   = st_q.warn_pend;
                if (mismatch) begin
                    st_d.fault     = 1'b1;
                    st_d.new_frame = 1'b1;
                    st_d.invpc     = 1'b1;
                end else begin
                    st_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr_o        = st_q.sp;
    assign busy_o            = (st_q.state != ST_IDLE);
    assign done_o            = st_q.done;
    assign fault_o           = st_q.fault;
    assign fault_new_frame_o = st_q.new_frame;
    assign pend_exc_o        = st_q.fault ? EXC_W'(USAGE_EXC) : '0;
    assign fault_lr_o        = st_q.lr;
    assign use_psp_o         = st_q.psp;
    assign handler_mode_o    = st_q.handler;
    assign sp_o              = st_q.sp;
    assign frame_o           = st_q.frame;
    assign faultmask_clr_o   = st_q.fm_clr;
    assign hibits_warn_o     = st_q.warn;
    assign invpc_o           = st_q.invpc;

    // R12
    done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o));

    // R7
    prepop_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !fault_new_frame_o) |-> !$past(mem_rd_o));

    // R11
    fault_sets_invpc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> invpc_o);

    // R10
    fault_lr_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (fault_lr_o[DW-1:DW-4] == 4'hF));

    // R9
    align_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && frame_o[XPSR_IX*DW + ALIGN_BIT]) |-> sp_o[2]);
endmodule

// File: tb/exc_return_checker_bench.sv
module exc_return_checker_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MSP_BASE = 32'h40;
    localparam logic [31:0] PSP_BASE = 32'h88;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  ret_val = '0;
    logic [8:0]   cur_exc = '0;
    logic [1:0]   nest = '0;
    logic         nbte = 1'b0;
    logic         invpc_clr = 1'b0;
    logic         mem_rd;
    logic [31:0]  mem_addr;
    logic [31:0]  mem_rdata = '0;
    logic         busy, done, fault, new_frame, use_psp, hmode, fm_clr, warn, invpc;
    logic [8:0]   pend_exc;
    logic [31:0]  fault_lr, sp;
    logic [255:0] frame;
    logic [31:0]  mem [64];
    int           rd_cnt = 0;
    int           n_cmp = 0;
    int           n_bad = 0;
    int           cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_return_checker u_exc_return_checker (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ret_val_i(ret_val),
        .cur_exc_i(cur_exc), .nest_i(nest), .nonbase_thr_en_i(nbte),
        .msp_i(MSP_BASE), .psp_i(PSP_BASE), .invpc_clr_i(invpc_clr),
        .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .fault_o(fault),
        .fault_new_frame_o(new_frame), .pend_exc_o(pend_exc),
        .fault_lr_o(fault_lr), .use_psp_o(use_psp), .handler_mode_o(hmode),
        .sp_o(sp), .frame_o(frame), .faultmask_clr_o(fm_clr),
        .hibits_warn_o(warn), .invpc_o(invpc)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[7:2]];
            rd_cnt    <= rd_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [3:0] nib, input logic [1:0] ns, input logic nb,
                           input logic [8:0] cx, input logic [8:0] xexc, input logic b9,
                           input logic hibad);
        logic [31:0] rv, base, xpsr, exp_sp;
        logic        thread, kind_ok, pre, hreq, mis, nmi;
        int          wait_n;
        rv     = 32'hFFFF_FFE0 | {28'd0, nib};
        if (hibad) rv[12] = 1'b0;
        hreq   = (nib == 4'd1);
        thread = (nib == 4'd9) || (nib == 4'd13);
        kind_ok = hreq || thread;
        pre    = !kind_ok || !(ns == 2'b00 || ns == 2'b01) || (thread && ns == 2'b00 && !nb);
        base   = (nib == 4'd13) ? PSP_BASE : MSP_BASE;
        xpsr   = 32'h0100_0000 | {22'd0, b9, xexc};
        mem[base[7:2] + 7] = xpsr;
        mis    = hreq == (xexc == 9'd0);
        nmi    = (cx == 9'd2);
        exp_sp = (base + 32'd32) | (b9 ? 32'd4 : 32'd0);

        @(negedge clk);
        ret_val = rv; nest = ns; nbte = nb; cur_exc = cx; rd_cnt = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_n = 0;
        while (!(done || fault) && wait_n < 60) begin
            @(negedge clk);
            wait_n++;
        end
        if (!(done || fault)) begin
            n_cmp++; n_bad++;
            $display("FAIL R12: actual no completion expected done or fault");
            return;
        end
        check("R2 warn", {31'd0, warn}, {31'd0, hibad});
        check("R3 faultmask clear", {31'd0, fm_clr}, {31'd0, !nmi});
        if (pre) begin
            // R4 R5 R6 R7
            check("R7 pre-pop fault", {30'd0, done, fault}, 32'd1);
            check("R7 new frame", {31'd0, new_frame}, 32'd0);
            check("R7 reads", rd_cnt, 32'd0);
            check("R7 lr", fault_lr, rv | 32'hF000_0000);
            check("R7 pend", {23'd0, pend_exc}, 32'd6);
            check("R7 wait", wait_n, 32'd0);
            check("R11 invpc", {31'd0, invpc}, 32'd1);
        end else begin
            check("R8 reads", rd_cnt, 32'd8);
            check("R8 stack", {31'd0, use_psp}, {31'd0, nib == 4'd13});
            check("R8 mode", {31'd0, hmode}, {31'd0, hreq});
            for (int k = 0; k < 8; k++)
                check("R8 word", frame[32*k +: 32], mem[base[7:2] + 6'(k)]);
            check("R9 sp", sp, exp_sp);
            if (mis) begin
                check("R10 mismatch fault", {30'd0, done, fault}, 32'd1);
                check("R10 new frame", {31'd0, new_frame}, 32'd1);
                check("R10 lr", fault_lr, rv | 32'hF000_0000);
                check("R10 pend", {23'd0, pend_exc}, 32'd6);
            end else begin
                check("R10 done", {30'd0, done, fault}, 32'd2);
            end
        end
        @(negedge clk);
        check("R12 pulse", {30'd0, done, fault}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 | (i << 8) | i;
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset", {25'd0, busy, done, fault, mem_rd, invpc, fm_clr, warn}, 32'd0);
        rst_n = 1'b1;
        for (int nib = 0; nib < 16; nib++)
            for (int ni = 0; ni < 3; ni++)
                for (int nb = 0; nb < 2; nb++)
                    for (int c = 0; c < 2; c++)
                        for (int x = 0; x < 2; x++)
                            run_one(4'(nib), (ni == 2) ? 2'b11 : 2'(ni), nb[0],
                                    c ? 9'd5 : 9'd2, x ? 9'd3 : 9'd0,
                                    nib[1] ^ x[0], ((nib + ni + c) % 3) == 0);
        // R4 unused code faults
        run_one(4'd9, 2'b10, 1'b1, 9'd5, 9'd0, 1'b0, 1'b0);
        // R11 sticky clear
        @(negedge clk);
        check("R11 still set", {31'd0, invpc}, 32'd1);
        invpc_clr = 1'b1;
        @(negedge clk);
        invpc_clr = 1'b0;
        check("R11 cleared", {31'd0, invpc}, 32'd0);
        run_one(4'd9, 2'b01, 1'b0, 9'd5, 9'd0, 1'b0, 1'b0);
        check("R11 no fault keeps clear", {31'd0, invpc}, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule